// File: doc/BRIEF.md
# TDM Channel-Control Bit Serializer

This block drives four serial control lines that tell external circuitry, one channel at a time, whether each of 32 time-division-multiplexed output streams should be driven or released to high impedance. Each line serves eight streams, interleaved one bit per clock. A line carries a new bit every period of the 16.384 MHz bit clock, whatever data rate each stream runs at. The value of each bit is the channel's output-enable bit, fetched through a lookup port from an external per-stream, per-channel table. A 0 means "release to high impedance".

A mode strap is captured while reset is asserted. With the strap low, all 32 stream output enables are held high and per-channel tristating is left to external logic steered by the four lines. With the strap high, the block produces a per-stream output enable itself. That enable is retimed from the same control bits so that it changes on channel boundaries rather than ahead of them. A frame pulse, given in the last bit period of each 2048-period frame, aligns an internal position counter. A three-state machine decides when the lines carry valid data. Its states are ST_WAIT_SYNC (no frame pulse seen yet), ST_PRIME (the lookup pipeline is filling) and ST_STREAM (normal output). Its transitions are:
- WAIT_SYNC→PRIME on any frame pulse;
- PRIME→PRIME on a new pulse;
- PRIME→STREAM once the pipeline is full;
- STREAM→PRIME on a pulse that arrives anywhere other than the last frame position.

Top module: `tdm_ctl_serializer`

## Requirements
- R1: In the cycles after a clock edge with `rst_n` low, `ctl_line` is all zeros and `stream_oe` is all zeros.
- R2: `mode_strap` is captured only on clock edges while `rst_n` is low. Changing it after reset has no effect on `stream_oe`.
- R3: With the captured strap at 0 (external mode), every bit of `stream_oe` is 1 from the second cycle after reset release.
- R4: Line n carries only streams whose index modulo 4 equals n. In bit slot k (0..7) of each 8-slot group it carries stream n+4k, and it presents that stream index on its `lk_stream` field.
- R5: At frame position t, the bit on every line belongs to slot k = ((t+10) mod 2048) mod 8 of group g = ((t+10) mod 2048) / 8. So the channel-0 bit of stream 0 appears at position 2038 (10 periods early), and the channel-0 bits of streams 28..31 appear at position 2045 (3 periods early).
- R6: Stream rate codes are 2'b00 = 2.048, 2'b01 = 4.096, 2'b10 = 8.192 and 2'b11 = 16.384 Mb/s. The channel looked up for group g is g >> (3 − code), so each bit repeats 8, 4, 2 or 1 times.
- R7: The lookup port returns `lk_oe` one clock after `lk_stream`/`lk_chan` are presented. The line shows that bit in the following cycle.
- R8: A frame pulse sampled high marks the last position (2047). The next cycle is position 0. Without a pulse the position wraps from 2047 to 0 on its own, and streaming continues.
- R9: Until the first frame pulse, and during the two priming cycles after it (positions 0 and 1), all lines are 0.
- R10: A frame pulse that arrives at any position other than 2047 during streaming realigns the position to 0 and forces two cycles of 0 on all lines before valid bits resume.
- R11: In internal mode (captured strap 1), `stream_oe[s]` for s = n+4k holds, during positions 8g..8g+7, the bit that line n carried at position 8g−10+k. That is stream s's enable for its channel of group g. `stream_oe` changes only when the position is a multiple of 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16.384 MHz bit clock |
| rst_n | input | 1 | Synchronous active-low reset; strap capture window |
| mode_strap | input | 1 | 1 = internal per-channel tristate, 0 = external control |
| frame_sync | input | 1 | High in the last bit period of a frame |
| stream_rate | input | 64 | 2-bit rate code per stream, stream s at bits 2s+1:2s |
| lk_stream | output | 20 | Per-line lookup stream index, line n at bits 5n+4:5n |
| lk_chan | output | 32 | Per-line lookup channel index, line n at bits 8n+7:8n |
| lk_oe | input | 4 | Per-line enable bit returned one clock after the lookup |
| ctl_line | output | 4 | Serial control lines, one bit per clock |
| stream_oe | output | 32 | Per-stream output enable, 1 = drive |

## Verification
The lines are compared with a bench-computed model at every position of several full frames. The rate assignment places all four rate codes on every line, so a wrong interleave, a wrong lead or a wrong repetition shift each produce mismatches in distinct slots. The frame pulse is applied in four ways: first sync from the waiting state, aligned pulses, a skipped pulse, and a misaligned pulse mid-frame. These separate the priming, flywheel and realignment behaviour. The strap is flipped after each reset release, in both modes. The 32 enables are checked group by group in internal mode and as a constant in external mode, which distinguishes retiming errors from mode-capture errors.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

    localparam int RATE_W = 2;

    typedef enum logic [1:0] {
        ST_WAIT_SYNC = 2'd0,
        ST_PRIME     = 2'd1,
        ST_STREAM    = 2'd2
    } sync_state_e;

    typedef enum logic [1:0] {
        RATE_2M048  = 2'b00,
        RATE_4M096  = 2'b01,
        RATE_8M192  = 2'b10,
        RATE_16M384 = 2'b11
    } stream_rate_e;

    // log2 of how many 8-slot groups one channel of the stream spans
    function automatic logic [1:0] rep_log2(input logic [RATE_W-1:0] code);
        logic [1:0] r;
        unique case (stream_rate_e'(code))
            RATE_16M384: r = 2'd0;
            RATE_8M192:  r = 2'd1;
            RATE_4M096:  r = 2'd2;
            RATE_2M048:  r = 2'd3;
            default:     r = 2'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tcs_frame_timer.sv
module tcs_frame_timer
    import tcs_pkg::*;
#(
    parameter int FRAME_LEN = 2048,
    parameter int PIPE      = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         frame_sync,
    output logic [$clog2(FRAME_LEN)-1:0] pos,
    output sync_state_e                  state,
    output logic                         load_line
);

    localparam int POS_W   = $clog2(FRAME_LEN);
    localparam int PRIME_W = $clog2(PIPE + 1);
    localparam logic [POS_W-1:0]   LAST_POS   = POS_W'(FRAME_LEN - 1);
    localparam logic [PRIME_W-1:0] PRIME_LAST = PRIME_W'(PIPE - 1);

    sync_state_e          state_q, state_d;
    logic [POS_W-1:0]     pos_q;
    logic [PRIME_W-1:0]   prime_q;
    logic                 at_end;
    logic                 realign;
    logic                 prime_done;

    assign at_end     = (pos_q == LAST_POS);
    assign realign    = frame_sync && !((state_q == ST_STREAM) && at_end);
    assign prime_done = (prime_q == PRIME_LAST);

    // frame position counter: pulse forces the next cycle to position 0
    always_ff @(posedge clk) begin
        if (!rst_n)
            pos_q <= '0;
        else if (frame_sync)
            pos_q <= '0;
        else
            pos_q <= pos_q + 1'b1;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_WAIT_SYNC;
        else
            state_q <= state_d;
    end

    // priming counter
    always_ff @(posedge clk) begin
        if (!rst_n)
            prime_q <= '0;
        else if (realign)
            prime_q <= '0;
        else if ((state_q == ST_PRIME) && !prime_done)
            prime_q <= prime_q + 1'b1;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_SYNC: if (realign) state_d = ST_PRIME;
            ST_PRIME: begin
                if (realign)
                    state_d = ST_PRIME;
                else if (prime_done)
                    state_d = ST_STREAM;
            end
            ST_STREAM:    if (realign) state_d = ST_PRIME;
            default:      state_d = ST_WAIT_SYNC;
        endcase
    end

    // outputs
    always_comb begin
        load_line = 1'b0;
        unique case (state_q)
            ST_WAIT_SYNC: load_line = 1'b0;
            ST_PRIME:     load_line = !realign && prime_done;
            ST_STREAM:    load_line = !realign;
            default:      load_line = 1'b0;
        endcase
    end

    assign pos   = pos_q;
    assign state = state_q;

endmodule

// File: rtl/tcs_lookup_gen.sv
module tcs_lookup_gen
    import tcs_pkg::*;
#(
    parameter int LINES     = 4,
    parameter int STREAMS   = 32,
    parameter int FRAME_LEN = 2048,
    parameter int LEAD      = 10,
    parameter int PIPE      = 2
) (
    input  logic [$clog2(FRAME_LEN)-1:0]                                   pos,
    input  logic [STREAMS*RATE_W-1:0]                                      stream_rate,
    output logic [LINES*$clog2(STREAMS)-1:0]                               lk_stream,
    output logic [LINES*($clog2(FRAME_LEN)-$clog2(STREAMS/LINES))-1:0]     lk_chan
);

    localparam int POS_W    = $clog2(FRAME_LEN);
    localparam int GROUP    = STREAMS / LINES;
    localparam int GRP_W    = $clog2(GROUP);
    localparam int LINE_W   = $clog2(LINES);
    localparam int STREAM_W = $clog2(STREAMS);
    localparam int CHAN_W   = POS_W - GRP_W;

    logic [POS_W-1:0]  slot;
    logic [GRP_W-1:0]  member;
    logic [CHAN_W-1:0] grp;

    // slot whose bit must leave the line PIPE cycles from now, advanced by LEAD
    assign slot   = pos + POS_W'(PIPE + LEAD);
    assign member = slot[GRP_W-1:0];
    assign grp    = slot[POS_W-1:GRP_W];

    for (genvar n = 0; n < LINES; n++) begin : g_line
        logic [STREAM_W-1:0] sid;
        logic [RATE_W-1:0]   code;
        logic [1:0]          sh;

        assign sid  = {member, LINE_W'(n)};
        assign code = stream_rate[sid*RATE_W +: RATE_W];
        assign sh   = rep_log2(code);

        assign lk_stream[n*STREAM_W +: STREAM_W] = sid;
        assign lk_chan[n*CHAN_W +: CHAN_W]       = grp >> sh;
    end

endmodule

// File: rtl/tcs_oe_tracker.sv
module tcs_oe_tracker #(
    parameter int LINES   = 4,
    parameter int STREAMS = 32,
    parameter int LEAD    = 10
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               mode_int,
    input  logic [$clog2(STREAMS/LINES)-1:0]   grp_phase,
    input  logic [LINES-1:0]                   ctl_line,
    output logic [STREAMS-1:0]                 stream_oe
);

    localparam int GROUP = STREAMS / LINES;

    // dly_q[j] holds the line value from j cycles earlier
    logic [LINES-1:0]   dly_q [1:LEAD-1];
    logic [STREAMS-1:0] oe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 1; j < LEAD; j++) dly_q[j] <= '0;
        end else begin
            dly_q[1] <= ctl_line;
            for (int j = 2; j < LEAD; j++) dly_q[j] <= dly_q[j-1];
        end
    end

    // on the last cycle of a group, slot k of line n was sent LEAD-1-k cycles ago
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q <= '0;
        end else if (!mode_int) begin
            oe_q <= '1;
        end else if (&grp_phase) begin
            for (int k = 0; k < GROUP; k++)
                for (int n = 0; n < LINES; n++)
                    oe_q[k*LINES + n] <= dly_q[LEAD-1-k][n];
        end
    end

    assign stream_oe = oe_q;

endmodule

// File: rtl/tdm_ctl_serializer.sv
module tdm_ctl_serializer
    import tcs_pkg::*;
#(
    parameter int LINES     = 4,
    parameter int STREAMS   = 32,
    parameter int FRAME_LEN = 2048,
    parameter int LEAD      = 10,
    parameter int PIPE      = 2
) (
    input  logic                                                         clk,
    input  logic                                                         rst_n,
    input  logic                                                         mode_strap,
    input  logic                                                         frame_sync,
    input  logic [STREAMS*2-1:0]                                         stream_rate,
    output logic [LINES*$clog2(STREAMS)-1:0]                             lk_stream,
    output logic [LINES*($clog2(FRAME_LEN)-$clog2(STREAMS/LINES))-1:0]   lk_chan,
    input  logic [LINES-1:0]                                             lk_oe,
    output logic [LINES-1:0]                                             ctl_line,
    output logic [STREAMS-1:0]                                           stream_oe
);

    localparam int POS_W = $clog2(FRAME_LEN);
    localparam int GRP_W = $clog2(STREAMS / LINES);

    logic             mode_q;
    logic [POS_W-1:0] pos_w;
    sync_state_e      st_w;
    logic             load_w;
    logic [LINES-1:0] line_q;

    // strap is captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= mode_strap;
    end

    tcs_frame_timer #(
        .FRAME_LEN (FRAME_LEN),
        .PIPE      (PIPE)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .pos        (pos_w),
        .state      (st_w),
        .load_line  (load_w)
    );

    tcs_lookup_gen #(
        .LINES     (LINES),
        .STREAMS   (STREAMS),
        .FRAME_LEN (FRAME_LEN),
        .LEAD      (LEAD),
        .PIPE      (PIPE)
    ) u_lookup (
        .pos         (pos_w),
        .stream_rate (stream_rate),
        .lk_stream   (lk_stream),
        .lk_chan     (lk_chan)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            line_q <= '0;
        else if (load_w)
            line_q <= lk_oe;
        else
            line_q <= '0;
    end

    assign ctl_line = line_q;

    tcs_oe_tracker #(
        .LINES   (LINES),
        .STREAMS (STREAMS),
        .LEAD    (LEAD)
    ) u_oe (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_int  (mode_q),
        .grp_phase (pos_w[GRP_W-1:0]),
        .ctl_line  (line_q),
        .stream_oe (stream_oe)
    );

endmodule

// File: rtl/tcs_checker.sv
module tcs_checker
    import tcs_pkg::*;
#(
    parameter int LINES   = 4,
    parameter int STREAMS = 32
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               mode_strap,
    input logic [LINES-1:0]                   lk_oe,
    input logic [LINES-1:0]                   ctl_line,
    input logic [STREAMS-1:0]                 stream_oe,
    input logic [1:0]                         st,
    input logic [$clog2(STREAMS/LINES)-1:0]   grp_phase
);

    logic cap_q;
    logic rst_prev;

    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= mode_strap;
    end

    always @(posedge clk) rst_prev <= rst_n;

    // R1: outputs cleared after a reset edge
    always @(posedge clk) begin
        if (rst_prev === 1'b0)
            a_r1_reset_clears: assert (ctl_line == '0 && stream_oe == '0)
                else $error("R1 outputs not cleared by reset");
    end

    // R3: external mode drives every stream
    a_r3_ext_all_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_q && $past(rst_n)) |-> (&stream_oe));

    // R7: streaming line equals the lookup bit returned one cycle earlier
    a_r7_line_follows_lookup: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STREAM && $past(st) == ST_STREAM && $past(rst_n)) |-> (ctl_line == $past(lk_oe)));

    // R9 / R10: lines quiet whenever not streaming
    a_r9_idle_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_STREAM) |-> (ctl_line == '0));

    // R11: internal enables move only on group boundaries
    a_r11_oe_group_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_q && $past(rst_n) && grp_phase != '0) |-> $stable(stream_oe));

endmodule

bind tdm_ctl_serializer tcs_checker #(
    .LINES   (LINES),
    .STREAMS (STREAMS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_strap (mode_strap),
    .lk_oe      (lk_oe),
    .ctl_line   (ctl_line),
    .stream_oe  (stream_oe),
    .st         (st_w),
    .grp_phase  (pos_w[GRP_W-1:0])
);

// File: tb/tdm_ctl_serializer_test.sv
`timescale 1ns/1ps
module tdm_ctl_serializer_test;

    localparam int FR = 2048;
    localparam int LD = 10;
    localparam int LN = 4;
    localparam int NS = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mode_strap;
    logic        frame_sync;
    logic [63:0] stream_rate;
    logic [19:0] lk_stream;
    logic [31:0] lk_chan;
    logic [3:0]  lk_oe = '0;
    logic [3:0]  ctl_line;
    logic [31:0] stream_oe;

    int checks = 0;
    int fails  = 0;
    int seed   = 1;
    int rate [NS];
    int pos    = 0;
    int since  = 0;
    bit synced = 0;
    bit ext_mode = 0;

    always #2 clk = ~clk;

    tdm_ctl_serializer uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_strap  (mode_strap),
        .frame_sync  (frame_sync),
        .stream_rate (stream_rate),
        .lk_stream   (lk_stream),
        .lk_chan     (lk_chan),
        .lk_oe       (lk_oe),
        .ctl_line    (ctl_line),
        .stream_oe   (stream_oe)
    );

    function automatic bit en(input int s, input int c);
        return ((s * 37 + c * 11 + seed * 5) % 7) < 4;
    endfunction

    // enable table model: one-cycle read latency (R7)
    always @(posedge clk) begin
        for (int n = 0; n < LN; n++)
            lk_oe[n] <= en(int'(lk_stream[n*5 +: 5]), int'(lk_chan[n*8 +: 8]));
    end

    function automatic bit exp_line(input int n, input int t);
        int tp, k, g, s;
        tp = (t + LD) % FR;
        k  = tp % 8;
        g  = tp / 8;
        s  = n + 4 * k;
        return en(s, g >> (3 - rate[s]));
    endfunction

    task automatic chk(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s pos %0d got %0h exp %0h", tag, pos, got, exp);
        end
    endtask

    task automatic load_rates(input int variant);
        for (int s = 0; s < NS; s++) begin
            if (variant == 0) rate[s] = (s / 4 + s) % 4;
            else              rate[s] = (3 - (s % 4) + s / 8) % 4;
            stream_rate[s*2 +: 2] = 2'(rate[s]);
        end
    endtask

    task automatic verify();
        for (int n = 0; n < LN; n++) begin
            bit e;
            e = (synced && since >= 2) ? exp_line(n, pos) : 1'b0;
            if (synced && since >= 2)
                chk(ctl_line[n] == e, "R4 R5 R6 R7 R8 line", int'(ctl_line[n]), int'(e));
            else
                chk(ctl_line[n] == e, "R9 R10 quiet line", int'(ctl_line[n]), int'(e));
        end
        if (ext_mode) begin
            chk(stream_oe == '1, "R2 R3 external enables", int'(stream_oe), -1);
        end else if (!synced) begin
            chk(stream_oe == '0, "R2 internal enables idle", int'(stream_oe), 0);
        end else if (since >= 16) begin
            for (int s = 0; s < NS; s++) begin
                bit e;
                e = en(s, (pos / 8) >> (3 - rate[s]));
                chk(stream_oe[s] == e, "R11 stream enable", int'(stream_oe[s]), int'(e));
            end
        end
    endtask

    task automatic step(input bit fp);
        frame_sync = fp;
        @(posedge clk);
        if (fp && synced && pos == FR - 1) begin
            pos = 0; since++;
        end else if (fp) begin
            pos = 0; since = 0; synced = 1;
        end else begin
            pos = (pos + 1) % FR; since++;
        end
        @(negedge clk);
        frame_sync = 1'b0;
        verify();
    endtask

    task automatic run(input int cycles, input bit align);
        for (int i = 0; i < cycles; i++)
            step(align && synced && pos == FR - 1);
    endtask

    task automatic reset_check();
        chk(ctl_line == '0, "R1 reset lines", int'(ctl_line), 0);
        chk(stream_oe == '0, "R1 reset enables", int'(stream_oe), 0);
    endtask

    initial begin
        rst_n = 1'b0; frame_sync = 1'b0; mode_strap = 1'b0;
        seed = 1; load_rates(0);
        @(negedge clk);
        mode_strap = 1'b1;
        repeat (3) @(negedge clk);
        reset_check();
        // internal mode; strap flips after release must be ignored (R2)
        rst_n = 1'b1; mode_strap = 1'b0; synced = 0; ext_mode = 0;
        run(60, 1'b0);
        step(1'b1);                    // first sync from waiting state
        run(3 * FR, 1'b1);             // aligned pulses
        run(FR, 1'b0);                 // flywheel frame (R8)
        run((1000 - pos + FR) % FR, 1'b1);
        step(1'b1);                    // misaligned pulse (R10)
        run(2 * FR, 1'b1);

        // external mode phase
        @(negedge clk);
        rst_n = 1'b0; mode_strap = 1'b0; seed = 2; load_rates(1);
        synced = 0; pos = 0; since = 0;
        repeat (3) @(negedge clk);
        reset_check();
        rst_n = 1'b1; mode_strap = 1'b1;
        @(posedge clk);
        ext_mode = 1;
        @(negedge clk);
        verify();
        run(40, 1'b0);
        step(1'b1);
        run(2 * FR, 1'b1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog expired got %0d cycles exp fewer", 100000);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule